// File: doc/BRIEF.md
# Two-Level Masked Interrupt Collector

The block gathers event signals from three groups of sources: a power-button style level input, a watchdog expiry flag, and an analogue-converter group. The converter group has one conversion-complete strobe and a set of comparator outputs. Each source has its own trigger rule. When that rule fires, the source latches a sticky secondary status bit. The bit stays set until software clears it by writing a 1.

Each status bit is gated by its own mask bit. The unmasked bits of each group are ORed into that group's primary interrupt line. The three primary lines are then ORed into one request line for the processor. A status bit keeps latching while its mask is set, so software can poll a source without taking interrupts from it.

All inputs pass through a two-flop synchronizer before edge detection. Edge detection is held off until the synchronizer has filled with real samples, so a level that is present when reset releases is never taken as an event. A small register port reads status and masks, clears status, and writes masks.

Top module: `irq_collector`

## Requirements
- R1: A level change on any event input, applied between clock edges, shows in status after the third rising edge at which it is present, and not after the second.
- R2: Status bit 0 (button) sets on both a rising and a falling transition of `on_level`.
- R3: Status bit 1 (watchdog) sets on a 0-to-1 transition of `wdt_expire` only; a 1-to-0 transition leaves it clear.
- R4: Status bit 2 (conversion complete) sets on a 0-to-1 transition of `adc_ready` only.
- R5: Comparator k drives status bit 3+k. When `cmp_pol[k]`=1, the bit sets when `cmp_gt[k]` goes 0-to-1. When `cmp_pol[k]`=0, the bit sets when `cmp_gt[k]` goes 1-to-0, and a 0-to-1 transition leaves it clear.
- R6: Writing address 0 clears every status bit whose data bit is 1; data bits of 0 leave status unchanged.
- R7: If a trigger and a clear of the same bit land on the same edge, the bit ends set.
- R8: A mask bit of 1 keeps its status bit out of the interrupt lines, but the status bit still latches and reads back.
- R9: After reset, status reads 0, the mask reads all ones (0x7F), and all interrupt outputs are low.
- R10: An input held at a non-idle level across reset release records no event.
- R11: `on_irq` = bit0 AND NOT mask0, `wdt_irq` = bit1 AND NOT mask1, `adc_irq` = OR over bits 2..6 of status AND NOT mask, and `irq` is the OR of the three.
- R12: Address 0 reads status and address 1 reads the mask; writing address 1 loads the mask from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_level | input | 1 | Button level, dual-edge event |
| wdt_expire | input | 1 | Watchdog expiry flag, rising-edge event |
| adc_ready | input | 1 | Conversion-complete flag, rising-edge event |
| cmp_gt | input | NCMP | Comparator greater-than results |
| cmp_pol | input | NCMP | Per-comparator direction select (1 = rising of result) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_wdata | input | NCMP+3 | Write data (clear bits or new mask) |
| reg_rdata | output | NCMP+3 | Read data for the selected register |
| on_irq | output | 1 | Button group interrupt |
| wdt_irq | output | 1 | Watchdog group interrupt |
| adc_irq | output | 1 | Converter group interrupt |
| irq | output | 1 | Overall interrupt request |

## Verification
The hardest case to reach is a trigger and a clear of the same bit landing on the same edge. Reaching it takes an input transition placed exactly two edges before a write, because the synchronizer adds delay. The bench changes the input and waits two edges. It then holds a write-1 to that bit across the third edge and reads the bit back as set. A random phase with a behavioural model keeps putting writes and transitions close together, so coincidences happen on many bits. The reset-release case is reached by holding the button input high through reset.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NCMP = 4,
  localparam int NB = NCMP + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on_level,
  input  logic            wdt_expire,
  input  logic            adc_ready,
  input  logic [NCMP-1:0] cmp_gt,
  input  logic [NCMP-1:0] cmp_pol,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [NB-1:0]   reg_wdata,
  output logic [NB-1:0]   reg_rdata,
  output logic            on_irq,
  output logic            wdt_irq,
  output logic            adc_irq,
  output logic            irq
);
  logic [NB-1:0] raw, s1, s2, s3, status, mask, set, clr;
  logic [1:0] fill;
  logic arm;
  logic [NCMP-1:0] t_now, t_old;

  assign raw = {cmp_gt, adc_ready, wdt_expire, on_level};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; fill <= '0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2;
      if (fill != 2'd3) fill <= fill + 2'd1;
    end

  // edges are only trusted once s3 holds a real sample
  assign arm   = (fill == 2'd3);
  assign t_now = ~(s2[NB-1:3] ^ cmp_pol);
  assign t_old = ~(s3[NB-1:3] ^ cmp_pol);
  assign set   = arm ? {t_now & ~t_old, s2[2] & ~s3[2], s2[1] & ~s3[1], s2[0] ^ s3[0]} : '0;
  assign clr   = (reg_wr && !reg_addr) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~clr) | set;
      if (reg_wr && reg_addr) mask <= reg_wdata;
    end

  assign reg_rdata = reg_addr ? mask : status;
  assign on_irq    = status[0] & ~mask[0];
  assign wdt_irq   = status[1] & ~mask[1];
  assign adc_irq   = |(status[NB-1:2] & ~mask[NB-1:2]);
  assign irq       = on_irq | wdt_irq | adc_irq;

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((status & $past(set)) == $past(set)));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> ((status & $past(reg_wdata & ~set)) == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && !(reg_wr && !reg_addr)) |=> $stable(status));

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  a_r10_no_early_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != 2'd3) |=> (status == '0 || $stable(status) || $past(reg_wr)));
endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;
  localparam int NCMP = 4;
  localparam int NB = NCMP + 3;

  logic clk = 0, rst_n = 0;
  logic on_level = 0, wdt_expire = 0, adc_ready = 0;
  logic [NCMP-1:0] cmp_gt = '0, cmp_pol = '1;
  logic reg_wr = 0, reg_addr = 0;
  logic [NB-1:0] reg_wdata = '0, reg_rdata;
  logic on_irq, wdt_irq, adc_irq, irq;

  int vectors = 0, fails = 0;
  logic [NB-1:0] m_st, m_mk;
  logic [NB-1:0] q[$];

  always #5ns clk = ~clk;

  irq_collector #(.NCMP(NCMP)) uut (.*);

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_mk = '1; q.delete();
    end else begin
      logic [NB-1:0] sv, cur, old;
      sv = '0;
      if (q.size() >= 3) begin
        cur = q[q.size()-1]; old = q[q.size()-3+1-1];
        old = q[q.size()-2];
        cur = q[q.size()-1];
        // q[$] is the newest sample (s1); s2 is one back, s3 two back
        cur = q[q.size()-2]; old = q[q.size()-3];
        sv[0] = cur[0] != old[0];
        sv[1] = cur[1] && !old[1];
        sv[2] = cur[2] && !old[2];
        for (int k = 0; k < NCMP; k++) begin
          bit tn, to;
          tn = cmp_pol[k] ? cur[3+k] : !cur[3+k];
          to = cmp_pol[k] ? old[3+k] : !old[3+k];
          sv[3+k] = tn && !to;
        end
      end
      if (reg_wr && reg_addr) m_mk = reg_wdata;
      m_st = (m_st & ~((reg_wr && !reg_addr) ? reg_wdata : '0)) | sv;
      q.push_back({cmp_gt, adc_ready, wdt_expire, on_level});
      if (q.size() > 4) void'(q.pop_front());
    end
  end

  task automatic chk(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    chk("R12 rdata", reg_rdata, reg_addr ? m_mk : m_st);
    chk("R11 on_irq", on_irq, m_st[0] & ~m_mk[0]);
    chk("R11 wdt_irq", wdt_irq, m_st[1] & ~m_mk[1]);
    chk("R11 adc_irq", adc_irq, |(m_st[NB-1:2] & ~m_mk[NB-1:2]));
    chk("R11 irq", irq, |(m_st & ~m_mk & {NB{1'b1}}));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(logic a, logic [NB-1:0] exp, string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic a, logic [NB-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    on_level = 1;
    ticks(3);
    rst_n = 1;
    ticks(6);
    rd(1, 7'h7F, "R9 mask reset");
    chk("R9 irq low", {on_irq, wdt_irq, adc_irq, irq}, '0);
    rd(0, 7'h00, "R10 no event from reset level");

    on_level = 0;
    ticks(2); rd(0, 7'h00, "R1 not after second edge");
    tick();   rd(0, 7'h01, "R1 after third edge");
    chk("R2 falling sets", reg_rdata, 7'h01);
    wr(0, 7'h00); rd(0, 7'h01, "R6 zero write ignored");
    wr(0, 7'h01); rd(0, 7'h00, "R6 one write clears");
    on_level = 1; ticks(3); rd(0, 7'h01, "R2 rising sets");
    wr(0, 7'h01);

    wdt_expire = 1; ticks(3); rd(0, 7'h02, "R3 rising sets");
    wr(0, 7'h02); wdt_expire = 0; ticks(4); rd(0, 7'h00, "R3 falling ignored");
    adc_ready = 1; ticks(3); rd(0, 7'h04, "R4 rising sets");
    wr(0, 7'h04); adc_ready = 0; ticks(4); rd(0, 7'h00, "R4 falling ignored");

    cmp_pol = 4'b1101; ticks(2);
    cmp_gt[0] = 1; ticks(3); rd(0, 7'h08, "R5 pol1 rising");
    wr(0, 7'h08);
    cmp_gt[1] = 1; ticks(4); rd(0, 7'h00, "R5 pol0 rising ignored");
    cmp_gt[1] = 0; ticks(3); rd(0, 7'h10, "R5 pol0 falling sets");

    chk("R8 masked no irq", {adc_irq, irq}, 2'b00);
    wr(1, 7'h6F);
    chk("R11 adc group", {on_irq, wdt_irq, adc_irq, irq}, 4'b0011);
    wr(0, 7'h10);
    chk("R11 cleared", irq, 1'b0);
    on_level = 0; ticks(3); rd(0, 7'h01, "R8 latches while masked");
    chk("R8 on_irq masked", on_irq, 1'b0);
    wr(1, 7'h7E);
    chk("R11 on group", {on_irq, irq}, 2'b11);

    wr(0, 7'h01); on_level = 1; ticks(2);
    reg_wr = 1; reg_addr = 0; reg_wdata = 7'h01; tick(); reg_wr = 0;
    rd(0, 7'h01, "R7 set beats clear");
    wr(1, 7'h55); rd(1, 7'h55, "R12 mask readback");

    for (int i = 0; i < 3000; i++) begin
      on_level   = $urandom_range(0, 7) == 0 ? ~on_level : on_level;
      wdt_expire = $urandom_range(0, 1);
      adc_ready  = $urandom_range(0, 1);
      cmp_gt     = $urandom;
      if ($urandom_range(0, 99) == 0) cmp_pol = $urandom;
      reg_wr    = $urandom_range(0, 3) == 0;
      reg_addr  = $urandom_range(0, 1);
      reg_wdata = $urandom;
      tick();
    end
    reg_wr = 0;

    rst_n = 0; on_level = 1; ticks(2); rst_n = 1; ticks(5);
    rd(1, 7'h7F, "R9 mask after second reset");
    rd(0, 7'h00, "R10 after second reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule